// File: doc/BRIEF.md
# Inertial Sensor Start-up Sequencer

This block wakes an inertial measurement sensor over SPI once the chip is out of reset. It talks to a byte-level SPI master through a small request interface. The block offers one byte at a time, says whether chip select must stay low after that byte, and takes back the received byte when the master acknowledges. The SPI master is not part of the block. Inside, a framer builds register writes (address byte with bit 7 low, then one data byte) and register reads (address byte with bit 7 high, then one or more clocked-in data bytes under the same chip select).

On a `start` pulse a fixed program runs. It selects bank 0 and issues a soft reset, then waits one millisecond and confirms the identity register. Next it masks the interrupt sources in bank 0 and in bank 4, returns to bank 0, clears the interface format register and powers up the temperature, gyro and accelerometer channels in low-noise mode. After a 45 ms settle it writes the accelerometer and gyro range and rate bytes. The millisecond waits are counted in system clocks, derived from the `CLK_HZ` parameter. The full-scale and rate codes are parameters.

Success gives a one-cycle `done` pulse. A bus failure or a wrong identity value stops the program and sets `error`, which stays set until the next accepted `start`. A wrong identity value also sets `id_mismatch`.

Top module: `imu_boot_seq`

## Requirements
- R1: A register write is one chip-select frame of exactly two bytes: `{1'b0, addr[6:0]}`, then the data byte. `spi_keep_cs` is 1 on the first byte and 0 on the second.
- R2: A register read is one frame: `{1'b1, addr[6:0]}`, then N data bytes during which the block transmits 8'h00. `spi_keep_cs` is 1 on every byte except the last. The identity read uses N=1.
- R3: While `spi_req` is high and `spi_ack` is low, `spi_req` stays high and `spi_tx_byte` does not change. A byte is consumed in the cycle `spi_ack` is high, and `spi_rx_byte` is valid in that cycle.
- R4: The frames come in this order, written (addr,data) in hex: (76,00) (11,01), wait, read 75, (65,00) (66,00) (68,00) (69,00) (76,04) (4D,00) (4E,00) (76,00) (4C,00) (4E,0F), wait, (50,accel cfg) (4F,gyro cfg), and nothing after them.
- R5: Between the end of the soft-reset frame and the start of the identity read, `spi_req` stays low for at least CLK_HZ/1000 cycles.
- R6: If the identity byte is not 8'h47, the block raises `error` and `id_mismatch`, sends no further frame and gives no `done`.
- R7: Between the end of the power-up frame (4E,0F) and the start of the first configuration frame, `spi_req` stays low for at least 45*CLK_HZ/1000 cycles.
- R8: Each configuration byte is {fs[2:0], 1'b0, odr[3:0]}, built from the parameters. The accelerometer byte goes to 8'h50 and the gyro byte to 8'h4F.
- R9: If `spi_fail` is high with an acknowledge, the block ends that frame, sends no further frame, sets `error`, leaves `id_mismatch` low and gives no `done`.
- R10: `start` has no effect while a program is running.
- R11: After reset, `done`, `error`, `id_mismatch` and `spi_req` are 0. `done` is high for exactly one cycle when the program completes. `error` and `id_mismatch` stay set until an accepted `start`, and the clock edge that accepts the `start` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts the program when idle |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | Sticky failure flag |
| id_mismatch | output | 1 | Sticky flag: identity value was wrong |
| spi_req | output | 1 | A byte is offered to the SPI master |
| spi_tx_byte | output | 8 | Byte to shift out |
| spi_keep_cs | output | 1 | Keep chip select asserted after this byte |
| spi_ack | input | 1 | Master has consumed the offered byte |
| spi_rx_byte | input | 8 | Byte shifted in, valid with `spi_ack` |
| spi_fail | input | 1 | Bus failure, qualified by `spi_ack` |

## Verification
A wrong step index or a wrong op decode shows up at the very next frame boundary. The frame's address or data byte will not match, or a frame is added or missing. Wrong framer state shows up in the same frame, because a byte count or a chip-select hold error splits or merges frames. A timer fault is seen at the end of one wait, as a gap that is too short or too long. A flag fault is seen within one cycle of the result it belongs to.

// File: rtl/imu_boot_pkg.sv
package imu_boot_pkg;

   localparam int IDX_W = 5;

   typedef enum logic [1:0] {
      OP_WR   = 2'd0,
      OP_RD   = 2'd1,
      OP_WAIT = 2'd2,
      OP_END  = 2'd3
   } boot_op_e;

   typedef struct packed {
      boot_op_e   op;
      logic [6:0] addr;
      logic [7:0] arg;   // write data, expected read value, or milliseconds
   } boot_step_t;

   localparam logic [6:0] RA_BANK   = 7'h76;
   localparam logic [6:0] RA_RESET  = 7'h11;
   localparam logic [6:0] RA_IDENT  = 7'h75;
   localparam logic [6:0] RA_MASKA  = 7'h65;
   localparam logic [6:0] RA_MASKB  = 7'h66;
   localparam logic [6:0] RA_MASKC  = 7'h68;
   localparam logic [6:0] RA_MASKD  = 7'h69;
   localparam logic [6:0] RA_HIMSKA = 7'h4D;
   localparam logic [6:0] RA_HIMSKB = 7'h4E;  // bank 4 view
   localparam logic [6:0] RA_IFFMT  = 7'h4C;
   localparam logic [6:0] RA_POWER  = 7'h4E;  // bank 0 view
   localparam logic [6:0] RA_GCFG   = 7'h4F;
   localparam logic [6:0] RA_ACFG   = 7'h50;
   localparam logic [7:0] IDENT_VAL = 8'h47;

   function automatic boot_step_t mk(boot_op_e op, logic [6:0] a, logic [7:0] v);
      boot_step_t s;
      s.op   = op;
      s.addr = a;
      s.arg  = v;
      return s;
   endfunction

   function automatic boot_step_t prog_step(input logic [IDX_W-1:0] idx,
                                            input logic [7:0] gcfg,
                                            input logic [7:0] acfg);
      boot_step_t s;
      case (idx)
         5'd0:    s = mk(OP_WR,   RA_BANK,   8'h00);
         5'd1:    s = mk(OP_WR,   RA_RESET,  8'h01);
         5'd2:    s = mk(OP_WAIT, 7'h00,     8'd1);
         5'd3:    s = mk(OP_RD,   RA_IDENT,  IDENT_VAL);
         5'd4:    s = mk(OP_WR,   RA_MASKA,  8'h00);
         5'd5:    s = mk(OP_WR,   RA_MASKB,  8'h00);
         5'd6:    s = mk(OP_WR,   RA_MASKC,  8'h00);
         5'd7:    s = mk(OP_WR,   RA_MASKD,  8'h00);
         5'd8:    s = mk(OP_WR,   RA_BANK,   8'h04);
         5'd9:    s = mk(OP_WR,   RA_HIMSKA, 8'h00);
         5'd10:   s = mk(OP_WR,   RA_HIMSKB, 8'h00);
         5'd11:   s = mk(OP_WR,   RA_BANK,   8'h00);
         5'd12:   s = mk(OP_WR,   RA_IFFMT,  8'h00);
         5'd13:   s = mk(OP_WR,   RA_POWER,  8'h0F);
         5'd14:   s = mk(OP_WAIT, 7'h00,     8'd45);
         5'd15:   s = mk(OP_WR,   RA_ACFG,   acfg);
         5'd16:   s = mk(OP_WR,   RA_GCFG,   gcfg);
         default: s = mk(OP_END,  7'h00,     8'h00);
      endcase
      return s;
   endfunction

endpackage

// File: rtl/imu_boot_prog.sv
module imu_boot_prog
   import imu_boot_pkg::*;
#(
   parameter int GYRO_FS   = 0,
   parameter int GYRO_ODR  = 6,
   parameter int ACCEL_FS  = 0,
   parameter int ACCEL_ODR = 6
) (
   input  logic [IDX_W-1:0] idx,
   output boot_step_t       step
);
   localparam logic [7:0] GYRO_BYTE  = {3'(GYRO_FS),  1'b0, 4'(GYRO_ODR)};
   localparam logic [7:0] ACCEL_BYTE = {3'(ACCEL_FS), 1'b0, 4'(ACCEL_ODR)};

   always_comb step = prog_step(idx, GYRO_BYTE, ACCEL_BYTE);
endmodule

// File: rtl/imu_spi_framer.sv
module imu_spi_framer #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_go,
   input  logic             cmd_rd,
   input  logic [6:0]       cmd_addr,
   input  logic [7:0]       cmd_wdata,
   input  logic [LEN_W-1:0] cmd_len,
   output logic             cmd_done,
   output logic             cmd_fail,
   output logic             rd_strobe,
   output logic [7:0]       rd_data,
   output logic             spi_req,
   output logic [7:0]       spi_tx_byte,
   output logic             spi_keep_cs,
   input  logic             spi_ack,
   input  logic [7:0]       spi_rx_byte,
   input  logic             spi_fail
);
   typedef enum logic [1:0] {F_IDLE, F_ADDR, F_DATA, F_END} fstate_e;

   fstate_e          st;
   logic             rd_q, fail_q;
   logic [6:0]       addr_q;
   logic [7:0]       wdata_q;
   logic [LEN_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= F_IDLE;
         rd_q    <= 1'b0;
         fail_q  <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         remain  <= '0;
      end else begin
         case (st)
            F_IDLE: if (cmd_go) begin
               rd_q    <= cmd_rd;
               addr_q  <= cmd_addr;
               wdata_q <= cmd_wdata;
               remain  <= cmd_rd ? cmd_len : LEN_W'(1);
               fail_q  <= 1'b0;
               st      <= F_ADDR;
            end
            F_ADDR: if (spi_ack) begin
               if (spi_fail) begin
                  fail_q <= 1'b1;
                  st     <= F_END;
               end else begin
                  st <= F_DATA;
               end
            end
            F_DATA: if (spi_ack) begin
               remain <= remain - LEN_W'(1);
               if (spi_fail) begin
                  fail_q <= 1'b1;
                  st     <= F_END;
               end else if (remain == LEN_W'(1)) begin
                  st <= F_END;
               end
            end
            default: st <= F_IDLE;
         endcase
      end
   end

   always_comb begin
      spi_req     = (st == F_ADDR) || (st == F_DATA);
      spi_keep_cs = (st == F_ADDR) ? 1'b1 : (remain > LEN_W'(1));
      if (st == F_ADDR)  spi_tx_byte = {rd_q, addr_q};
      else if (rd_q)     spi_tx_byte = 8'h00;
      else               spi_tx_byte = wdata_q;
   end

   assign cmd_done  = (st == F_END);
   assign cmd_fail  = fail_q;
   assign rd_strobe = (st == F_DATA) && spi_ack && rd_q && !spi_fail;
   assign rd_data   = spi_rx_byte;
endmodule

// File: rtl/imu_ms_timer.sv
module imu_ms_timer #(
   parameter int CLK_HZ = 250_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] ms,
   output logic       expired
);
   localparam int CYC_PER_MS = CLK_HZ / 1000;
   localparam int CNT_W      = $clog2(CYC_PER_MS * 255 + 1);

   logic [CNT_W-1:0] cnt;
   logic             running;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
         expired <= 1'b0;
      end else begin
         expired <= 1'b0;
         if (go) begin
            cnt     <= CNT_W'(ms) * CNT_W'(CYC_PER_MS) - CNT_W'(1);
            running <= 1'b1;
         end else if (running) begin
            if (cnt == '0) begin
               running <= 1'b0;
               expired <= 1'b1;
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/imu_boot_seq.sv
module imu_boot_seq
   import imu_boot_pkg::*;
#(
   parameter int CLK_HZ    = 250_000_000,
   parameter int GYRO_FS   = 0,
   parameter int GYRO_ODR  = 6,
   parameter int ACCEL_FS  = 0,
   parameter int ACCEL_ODR = 6,
   parameter int LEN_W     = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   output logic       done,
   output logic       error,
   output logic       id_mismatch,
   output logic       spi_req,
   output logic [7:0] spi_tx_byte,
   output logic       spi_keep_cs,
   input  logic       spi_ack,
   input  logic [7:0] spi_rx_byte,
   input  logic       spi_fail
);
   generate
      if (GYRO_FS < 0 || GYRO_FS > 7 || ACCEL_FS < 0 || ACCEL_FS > 7) begin : g_bad_fs
         $error("full-scale code must fit in 3 bits");
      end
      if (GYRO_ODR < 0 || GYRO_ODR > 15 || ACCEL_ODR < 0 || ACCEL_ODR > 15) begin : g_bad_odr
         $error("rate code must fit in 4 bits");
      end
      if (CLK_HZ < 1000) begin : g_bad_clk
         $error("clock must be at least 1 kHz");
      end
      if (LEN_W < 2) begin : g_bad_len
         $error("burst length counter too narrow");
      end
   endgenerate

   typedef enum logic [1:0] {T_IDLE, T_STEP, T_XFER, T_WAIT} tstate_e;

   tstate_e          st;
   logic [IDX_W-1:0] idx;
   boot_step_t       step;
   logic [7:0]       rd_last;
   logic             cmd_go, cmd_done, cmd_fail, rd_strobe, tmr_go, tmr_exp;
   logic [7:0]       rd_data;

   imu_boot_prog #(
      .GYRO_FS(GYRO_FS), .GYRO_ODR(GYRO_ODR),
      .ACCEL_FS(ACCEL_FS), .ACCEL_ODR(ACCEL_ODR)
   ) u_prog (
      .idx  (idx),
      .step (step)
   );

   assign cmd_go = (st == T_STEP) && (step.op == OP_WR || step.op == OP_RD);
   assign tmr_go = (st == T_STEP) && (step.op == OP_WAIT);

   imu_spi_framer #(.LEN_W(LEN_W)) u_framer (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_go      (cmd_go),
      .cmd_rd      (step.op == OP_RD),
      .cmd_addr    (step.addr),
      .cmd_wdata   (step.arg),
      .cmd_len     (LEN_W'(1)),
      .cmd_done    (cmd_done),
      .cmd_fail    (cmd_fail),
      .rd_strobe   (rd_strobe),
      .rd_data     (rd_data),
      .spi_req     (spi_req),
      .spi_tx_byte (spi_tx_byte),
      .spi_keep_cs (spi_keep_cs),
      .spi_ack     (spi_ack),
      .spi_rx_byte (spi_rx_byte),
      .spi_fail    (spi_fail)
   );

   imu_ms_timer #(.CLK_HZ(CLK_HZ)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (tmr_go),
      .ms      (step.arg),
      .expired (tmr_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= T_IDLE;
         idx         <= '0;
         rd_last     <= '0;
         done        <= 1'b0;
         error       <= 1'b0;
         id_mismatch <= 1'b0;
      end else begin
         done <= 1'b0;
         if (rd_strobe) rd_last <= rd_data;
         case (st)
            T_IDLE: if (start) begin
               error       <= 1'b0;
               id_mismatch <= 1'b0;
               idx         <= '0;
               st          <= T_STEP;
            end
            T_STEP: begin
               case (step.op)
                  OP_WAIT: st <= T_WAIT;
                  OP_END: begin
                     done <= 1'b1;
                     st   <= T_IDLE;
                  end
                  default: st <= T_XFER;
               endcase
            end
            T_XFER: if (cmd_done) begin
               if (cmd_fail) begin
                  error <= 1'b1;
                  st    <= T_IDLE;
               end else if (step.op == OP_RD && rd_last != step.arg) begin
                  error       <= 1'b1;
                  id_mismatch <= 1'b1;
                  st          <= T_IDLE;
               end else begin
                  idx <= idx + IDX_W'(1);
                  st  <= T_STEP;
               end
            end
            default: if (tmr_exp) begin
               idx <= idx + IDX_W'(1);
               st  <= T_STEP;
            end
         endcase
      end
   end
endmodule

// File: rtl/imu_boot_chk.sv
module imu_boot_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       done,
   input logic       error,
   input logic       id_mismatch,
   input logic       spi_req,
   input logic [7:0] spi_tx_byte,
   input logic       spi_ack
);
   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_req && !spi_ack |=> spi_req && $stable(spi_tx_byte));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !error && !id_mismatch);

   // R6
   mism_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_mismatch |-> error);

   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error && !start |=> error);

   // R4
   quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !spi_req);
endmodule

bind imu_boot_seq imu_boot_chk u_chk (.*);

// File: tb/sim_imu_boot_seq.sv
module sim_imu_boot_seq;
   localparam int CLK_HZ = 250_000;
   localparam int CPM    = CLK_HZ / 1000;
   localparam int LAT    = 2;

   logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic       done, error, id_mismatch, spi_req, spi_keep_cs;
   logic [7:0] spi_tx_byte;
   logic       spi_ack = 1'b0, spi_fail = 1'b0;
   logic [7:0] spi_rx_byte = 8'h00;

   always #2 clk = ~clk;

   imu_boot_seq #(
      .CLK_HZ(CLK_HZ), .GYRO_FS(3), .GYRO_ODR(8), .ACCEL_FS(1), .ACCEL_ODR(15)
   ) u0 (.*);

   int          n_chk = 0, n_bad = 0, cyc = 0, frames = 0, done_cnt = 0, fail_frame = -1;
   bit          reported = 0;
   logic [7:0]  id_value = 8'h47;
   logic [15:0] exp_q[$];
   int          f_start[$], f_end[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      end
      $finish;
   endtask

   // expected frames from R4 / R8: accel {3'd1,0,4'hF}=2F, gyro {3'd3,0,4'h8}=68
   function automatic logic [15:0] exp_frame(int k);
      case (k)
         0: return 16'h7600;  1: return 16'h1100 | 16'h01;
         2: return 16'hF500;  3: return 16'h6500;  4: return 16'h6600;
         5: return 16'h6800;  6: return 16'h6900;  7: return 16'h7604;
         8: return 16'h4D00;  9: return 16'h4E00; 10: return 16'h7600;
         11: return 16'h4C00; 12: return 16'h4E0F; 13: return 16'h502F;
         default: return 16'h4F68;
      endcase
   endfunction

   task automatic drive_script(int upto);
      exp_q.delete();
      for (int k = 0; k < upto; k++) exp_q.push_back(exp_frame(k));
   endtask

   // SPI slave model and scoreboard monitor
   initial begin
      logic [7:0] cur[$];
      logic [7:0] held;
      int lat = 0;
      bit in_frame = 0, failed;
      forever begin
         @(negedge clk);
         if (spi_ack) begin
            spi_ack  = 1'b0;
            spi_fail = 1'b0;
         end else if (spi_req) begin
            if (!in_frame) begin
               in_frame = 1;
               f_start.push_back(cyc);
            end
            if (lat == 0) held = spi_tx_byte;
            if (lat == LAT) begin
               lat = 0;
               // R3: byte unchanged while waiting for acknowledge
               check(held == spi_tx_byte, "R3", spi_tx_byte, held);
               cur.push_back(spi_tx_byte);
               spi_ack     = 1'b1;
               spi_rx_byte = (cur.size() == 1) ? 8'h00 : id_value;
               failed      = (frames == fail_frame);
               spi_fail    = failed;
               if (!spi_keep_cs || failed) begin
                  in_frame = 0;
                  f_end.push_back(cyc);
                  if (!failed) begin
                     if (exp_q.size() == 0) begin
                        check(0, "R4 extra frame", {cur[0], 8'h00}, 0);
                     end else begin
                        logic [15:0] e, got;
                        e   = exp_q.pop_front();
                        got = {cur[0], (cur.size() > 1) ? cur[1] : 8'hXX};
                        check(cur.size() == 2, (frames == 2) ? "R2 length" : "R1 length",
                              cur.size(), 2);
                        check(got == e, (frames >= 13) ? "R8" : (frames == 2) ? "R2" : "R4",
                              got, e);
                     end
                  end
                  frames++;
                  cur.delete();
               end
            end else begin
               lat++;
            end
         end
      end
   end

   initial forever begin
      @(negedge clk);
      if (done) done_cnt++;
   end

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic new_run(logic [7:0] idv, int ff, int upto);
      id_value   = idv;
      fail_frame = ff;
      frames     = 0;
      f_start.delete();
      f_end.delete();
      drive_script(upto);
   endtask

   task automatic wait_end(string req);
      int n = 0;
      while (!done && !error && n < 30000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 30000) check(0, {req, " watchdog"}, n, 0);
   endtask

   task automatic idle_frames(int expf, string req);
      repeat (400) @(negedge clk);
      check(frames == expf, req, frames, expf);
   endtask

   initial begin
      #(4 * 190000);
      check(0, "watchdog", 0, 1);
      report();
   end

   initial begin
      int d0;
      repeat (5) @(negedge clk);
      // R11 reset state
      check(!done && !error && !id_mismatch && !spi_req, "R11 reset",
            {done, error, id_mismatch, spi_req}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // good run; a second start during the 45 ms wait must be ignored (R10)
      new_run(8'h47, -1, 15);
      d0 = done_cnt;
      pulse_start();
      while (frames < 13) @(negedge clk);
      repeat (50) @(negedge clk);
      pulse_start();
      wait_end("R4");
      @(negedge clk);
      check(exp_q.size() == 0, "R4 missing frames", exp_q.size(), 0);
      check(frames == 15, "R10 frame count", frames, 15);
      check(done_cnt - d0 == 1, "R11 done pulses", done_cnt - d0, 1);
      check(!error && !id_mismatch, "R11 flags", {error, id_mismatch}, 0);
      check(f_start[2] - f_end[1] >= CPM && f_start[2] - f_end[1] <= CPM + 20,
            "R5 gap", f_start[2] - f_end[1], CPM);
      check(f_start[13] - f_end[12] >= 45 * CPM && f_start[13] - f_end[12] <= 45 * CPM + 20,
            "R7 gap", f_start[13] - f_end[12], 45 * CPM);
      idle_frames(15, "R10 no restart");
      check(done_cnt - d0 == 1, "R10 done count", done_cnt - d0, 1);

      // wrong identity
      new_run(8'h12, -1, 3);
      d0 = done_cnt;
      pulse_start();
      wait_end("R6");
      @(negedge clk);
      check(error && id_mismatch, "R6 flags", {error, id_mismatch}, 2'b11);
      check(exp_q.size() == 0, "R6 frames", exp_q.size(), 0);
      idle_frames(3, "R6 stopped");
      check(done_cnt == d0, "R6 no done", done_cnt - d0, 0);
      check(error && id_mismatch, "R11 sticky", {error, id_mismatch}, 2'b11);

      // bus failure on frame 5; start clears the old flags
      new_run(8'h47, 5, 5);
      d0 = done_cnt;
      pulse_start();
      check(!error && !id_mismatch, "R11 clear on start", {error, id_mismatch}, 0);
      wait_end("R9");
      @(negedge clk);
      check(error && !id_mismatch, "R9 flags", {error, id_mismatch}, 2'b10);
      check(exp_q.size() == 0, "R9 frames", exp_q.size(), 0);
      idle_frames(6, "R9 stopped");
      check(done_cnt == d0, "R9 no done", done_cnt - d0, 0);

      // recovery
      new_run(8'h47, -1, 15);
      d0 = done_cnt;
      pulse_start();
      check(!error, "R11 clear on start", error, 0);
      wait_end("R4");
      @(negedge clk);
      check(exp_q.size() == 0 && frames == 15, "R4 recovery", frames, 15);
      check(done_cnt - d0 == 1 && !error, "R11 recovery done", done_cnt - d0, 1);
      report();
   end
endmodule